// File: doc/BRIEF.md
# Per-Thread Oldest-Squash Request Merger

In an out-of-order core the execute stage can raise several squash requests in one cycle: a branch that was mispredicted, a load or store that broke memory ordering, or a load that found memory blocked and has to run again. This block takes all of those requests for a cycle and, for each hardware thread, keeps only the oldest one, which is the one with the smallest sequence number. It registers one squash record per thread toward the commit stage. Each record holds a valid bit, the sequence number, the redirect PC, the instruction PC, a mispredict flag, a branch-taken bit and a flag that says whether the faulting instruction itself is squashed.

The request kind sets the redirect target and the squash boundary. A mispredict or an ordering violation resumes at the next instruction and keeps the faulting instruction. A blocked load resumes at its own PC and is squashed itself, so that it runs again. A query port tells execute whether an instruction may still redirect fetch in this cycle. The answer is taken from the merge being built from the same cycle's requests.

Top module: `sqm_top`

## Requirements
- R1: For each thread, a request is taken when no request for that thread has been taken yet in this cycle, or when its sequence number is strictly smaller than the one held. Requests are visited from port 0 upward, so on equal sequence numbers the lower port wins. Sequence numbers are compared as unsigned values with no wraparound handling.
- R2: A taken mispredict request (kind code 0) produces out_mispred=1, copies the branch-taken bit, sets out_redir_pc to the next-instruction PC and sets out_incl=0.
- R3: A taken ordering-violation request (kind code 1) produces out_mispred=0, out_taken=0, out_incl=0 and sets out_redir_pc to the next-instruction PC.
- R4: Kind code 3 is not a request. It changes no output, even when its valid bit is set.
- R5: A taken blocked-load request (kind code 2) produces out_mispred=0, out_taken=0, out_incl=1 and sets out_redir_pc to the instruction's own PC.
- R6: blk_handled for a thread is 1 for exactly one cycle, together with that cycle's record, when a blocked-load request for the thread was taken at its turn in port order. This holds even if an older request on a later port then replaces it. A rejected blocked-load request gives no pulse.
- R7: Threads are merged independently. A request for one thread never changes another thread's record.
- R8: wrote is 1 exactly in the cycles where at least one thread's record is valid.
- R9: qry_allow is 1 when fetch_redir for qry_tid is 0, when no request has been taken for that thread in the current cycle, or when the held sequence number is greater than qry_seq. Otherwise it is 0.
- R10: While rst_n is low, all registered outputs are 0.
- R11: Records appear one clock after their requests. Held state is cleared every cycle, so a younger request in a later cycle is taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | NUM_PORTS | Per-port request valid |
| req_kind | input | NUM_PORTS x 2 | Kind: 0 mispredict, 1 ordering, 2 blocked load, 3 none |
| req_tid | input | NUM_PORTS x TID_W | Thread of the request |
| req_seq | input | NUM_PORTS x SEQ_W | Sequence number, smaller is older |
| req_pc | input | NUM_PORTS x PC_W | Instruction PC |
| req_npc | input | NUM_PORTS x PC_W | PC of the next instruction |
| req_taken | input | NUM_PORTS | Branch-taken bit |
| fetch_redir | input | NUM_THREADS | Fetch redirect pending per thread |
| qry_tid | input | TID_W | Query thread |
| qry_seq | input | SEQ_W | Query sequence number |
| qry_allow | output | 1 | Instruction may still redirect fetch |
| out_valid | output | NUM_THREADS | Squash record valid |
| out_seq | output | NUM_THREADS x SEQ_W | Squash sequence number |
| out_redir_pc | output | NUM_THREADS x PC_W | Fetch restart PC |
| out_inst_pc | output | NUM_THREADS x PC_W | Faulting instruction PC |
| out_mispred | output | NUM_THREADS | Branch mispredict flag |
| out_taken | output | NUM_THREADS | Branch-taken bit |
| out_incl | output | NUM_THREADS | Faulting instruction is squashed as well |
| blk_handled | output | NUM_THREADS | Blocked-load acceptance pulse |
| wrote | output | 1 | At least one record is valid |

## Verification
On every cycle the assertions check that the records agree with themselves. A valid record needs a request for that thread in the previous cycle. An include-self record must redirect to its own PC and carry no mispredict. A mispredict record must not include itself. A non-mispredict record has the taken bit clear. A handled pulse needs a valid record, and the wrote flag must match the valid bits. Other rules depend on the actual numbers: that the oldest request wins, that ties go to the lower port, which record fields are copied from which request, what the query answers, and that state does not carry from one cycle to the next. Only the bench scenarios can show these, by comparing against a reference merge.

// File: rtl/sqm_pkg.sv
package sqm_pkg;
  parameter int unsigned SEQ_W = 16;
  parameter int unsigned PC_W  = 32;

  typedef enum logic [1:0] {
    SQK_MISPRED = 2'd0,
    SQK_ORDER   = 2'd1,
    SQK_MEMBLK  = 2'd2,
    SQK_NONE    = 2'd3
  } sq_kind_e;

  typedef struct packed {
    logic             pend;
    logic [SEQ_W-1:0] seq;
    logic [PC_W-1:0]  rpc;
    logic [PC_W-1:0]  ipc;
    logic             mispred;
    logic             taken;
    logic             incl;
  } sq_slot_t;
endpackage

// File: rtl/sqm_lane.sv
// One compare-and-take step: a single request port against one thread slot.
module sqm_lane
  import sqm_pkg::*;
#(
  parameter int unsigned TID_W  = 1,
  parameter int unsigned THREAD = 0
) (
  input  sq_slot_t         slot_in,
  input  logic             req_vld,
  input  logic [1:0]       req_kind,
  input  logic [TID_W-1:0] req_tid,
  input  logic [SEQ_W-1:0] req_seq,
  input  logic [PC_W-1:0]  req_pc,
  input  logic [PC_W-1:0]  req_npc,
  input  logic             req_taken,
  output sq_slot_t         slot_out,
  output logic             took_blk
);
  logic hit;
  logic older;
  logic take;

  always_comb begin
    hit      = req_vld && (req_kind != SQK_NONE) && (req_tid == TID_W'(THREAD));
    older    = !slot_in.pend || (req_seq < slot_in.seq);
    take     = hit && older;
    slot_out = slot_in;
    took_blk = 1'b0;
    if (take) begin
      slot_out.pend    = 1'b1;
      slot_out.seq     = req_seq;
      slot_out.ipc     = req_pc;
      slot_out.rpc     = req_npc;
      slot_out.mispred = 1'b0;
      slot_out.taken   = 1'b0;
      slot_out.incl    = 1'b0;
      unique case (req_kind)
        SQK_MISPRED: begin
          slot_out.mispred = 1'b1;
          slot_out.taken   = req_taken;
        end
        SQK_MEMBLK: begin
          slot_out.rpc  = req_pc;
          slot_out.incl = 1'b1;
          took_blk      = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sqm_thread_merge.sv
// Serial chain of lanes, port 0 first, producing one thread's merged slot.
module sqm_thread_merge
  import sqm_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned TID_W     = 1,
  parameter int unsigned THREAD    = 0
) (
  input  logic [NUM_PORTS-1:0]            req_vld,
  input  logic [NUM_PORTS-1:0][1:0]       req_kind,
  input  logic [NUM_PORTS-1:0][TID_W-1:0] req_tid,
  input  logic [NUM_PORTS-1:0][SEQ_W-1:0] req_seq,
  input  logic [NUM_PORTS-1:0][PC_W-1:0]  req_pc,
  input  logic [NUM_PORTS-1:0][PC_W-1:0]  req_npc,
  input  logic [NUM_PORTS-1:0]            req_taken,
  output sq_slot_t                        slot,
  output logic                            blk_hit
);
  sq_slot_t             chain [0:NUM_PORTS];
  logic [NUM_PORTS-1:0] blk_v;

  assign chain[0] = '0;

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_lane
    sqm_lane #(
      .TID_W (TID_W),
      .THREAD(THREAD)
    ) u_lane (
      .slot_in  (chain[gp]),
      .req_vld  (req_vld[gp]),
      .req_kind (req_kind[gp]),
      .req_tid  (req_tid[gp]),
      .req_seq  (req_seq[gp]),
      .req_pc   (req_pc[gp]),
      .req_npc  (req_npc[gp]),
      .req_taken(req_taken[gp]),
      .slot_out (chain[gp+1]),
      .took_blk (blk_v[gp])
    );
  end

  assign slot    = chain[NUM_PORTS];
  assign blk_hit = |blk_v;
endmodule

// File: rtl/sqm_query.sv
// Redirect permission against the merge being built this cycle.
module sqm_query
  import sqm_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 2,
  parameter int unsigned TID_W       = 1
) (
  input  sq_slot_t [NUM_THREADS-1:0] slots,
  input  logic [NUM_THREADS-1:0]     fetch_redir,
  input  logic [TID_W-1:0]           qry_tid,
  input  logic [SEQ_W-1:0]           qry_seq,
  output logic                       qry_allow
);
  sq_slot_t sel;
  logic     fr;

  always_comb begin
    sel       = slots[qry_tid];
    fr        = fetch_redir[qry_tid];
    qry_allow = !fr || !sel.pend || (sel.seq > qry_seq);
  end
endmodule

// File: rtl/sqm_top.sv
module sqm_top
  import sqm_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 2,
  parameter int unsigned NUM_PORTS   = 3,
  parameter int unsigned TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PORTS-1:0]              req_vld,
  input  logic [NUM_PORTS-1:0][1:0]         req_kind,
  input  logic [NUM_PORTS-1:0][TID_W-1:0]   req_tid,
  input  logic [NUM_PORTS-1:0][SEQ_W-1:0]   req_seq,
  input  logic [NUM_PORTS-1:0][PC_W-1:0]    req_pc,
  input  logic [NUM_PORTS-1:0][PC_W-1:0]    req_npc,
  input  logic [NUM_PORTS-1:0]              req_taken,
  input  logic [NUM_THREADS-1:0]            fetch_redir,
  input  logic [TID_W-1:0]                  qry_tid,
  input  logic [SEQ_W-1:0]                  qry_seq,
  output logic                              qry_allow,
  output logic [NUM_THREADS-1:0]            out_valid,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0] out_seq,
  output logic [NUM_THREADS-1:0][PC_W-1:0]  out_redir_pc,
  output logic [NUM_THREADS-1:0][PC_W-1:0]  out_inst_pc,
  output logic [NUM_THREADS-1:0]            out_mispred,
  output logic [NUM_THREADS-1:0]            out_taken,
  output logic [NUM_THREADS-1:0]            out_incl,
  output logic [NUM_THREADS-1:0]            blk_handled,
  output logic                              wrote
);
  sq_slot_t [NUM_THREADS-1:0] slots;
  logic [NUM_THREADS-1:0]     blk_hit;
  logic [NUM_THREADS-1:0]     valid_d;
  logic [NUM_THREADS-1:0]     handled_d;
  logic                       wrote_d;

  for (genvar gt = 0; gt < NUM_THREADS; gt++) begin : g_thr
    sqm_thread_merge #(
      .NUM_PORTS(NUM_PORTS),
      .TID_W    (TID_W),
      .THREAD   (gt)
    ) u_merge (
      .req_vld  (req_vld),
      .req_kind (req_kind),
      .req_tid  (req_tid),
      .req_seq  (req_seq),
      .req_pc   (req_pc),
      .req_npc  (req_npc),
      .req_taken(req_taken),
      .slot     (slots[gt]),
      .blk_hit  (blk_hit[gt])
    );
  end

  sqm_query #(
    .NUM_THREADS(NUM_THREADS),
    .TID_W      (TID_W)
  ) u_query (
    .slots      (slots),
    .fetch_redir(fetch_redir),
    .qry_tid    (qry_tid),
    .qry_seq    (qry_seq),
    .qry_allow  (qry_allow)
  );

  // next state
  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      valid_d[t]   = slots[t].pend;
      handled_d[t] = blk_hit[t];
    end
    wrote_d = |valid_d;
  end

  // flags: loaded every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= '0;
      blk_handled <= '0;
      wrote       <= 1'b0;
    end else begin
      out_valid   <= valid_d;
      blk_handled <= handled_d;
      wrote       <= wrote_d;
    end
  end

  // record payload: enabled only by a taken request
  for (genvar gt = 0; gt < NUM_THREADS; gt++) begin : g_rec
    logic rec_en;
    assign rec_en = slots[gt].pend;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_seq[gt]      <= '0;
        out_redir_pc[gt] <= '0;
        out_inst_pc[gt]  <= '0;
        out_mispred[gt]  <= 1'b0;
        out_taken[gt]    <= 1'b0;
        out_incl[gt]     <= 1'b0;
      end else if (rec_en) begin
        out_seq[gt]      <= slots[gt].seq;
        out_redir_pc[gt] <= slots[gt].rpc;
        out_inst_pc[gt]  <= slots[gt].ipc;
        out_mispred[gt]  <= slots[gt].mispred;
        out_taken[gt]    <= slots[gt].taken;
        out_incl[gt]     <= slots[gt].incl;
      end
    end
  end
endmodule

// File: rtl/sqm_checker.sv
module sqm_checker
  import sqm_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 2,
  parameter int unsigned NUM_PORTS   = 3,
  parameter int unsigned TID_W       = 1
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_PORTS-1:0]              req_vld,
  input logic [NUM_PORTS-1:0][1:0]         req_kind,
  input logic [NUM_PORTS-1:0][TID_W-1:0]   req_tid,
  input logic [NUM_THREADS-1:0]            out_valid,
  input logic [NUM_THREADS-1:0][PC_W-1:0]  out_redir_pc,
  input logic [NUM_THREADS-1:0][PC_W-1:0]  out_inst_pc,
  input logic [NUM_THREADS-1:0]            out_mispred,
  input logic [NUM_THREADS-1:0]            out_taken,
  input logic [NUM_THREADS-1:0]            out_incl,
  input logic [NUM_THREADS-1:0]            blk_handled,
  input logic                              wrote
);
  logic [NUM_THREADS-1:0] has_req;

  always_comb begin
    has_req = '0;
    for (int t = 0; t < NUM_THREADS; t++)
      for (int p = 0; p < NUM_PORTS; p++)
        if (req_vld[p] && req_kind[p] != SQK_NONE && req_tid[p] == TID_W'(t))
          has_req[t] = 1'b1;
  end

  for (genvar gt = 0; gt < NUM_THREADS; gt++) begin : g_chk
    p_valid_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[gt] |-> $past(has_req[gt]));
    p_incl_own_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[gt] && out_incl[gt]) |->
        (out_redir_pc[gt] == out_inst_pc[gt]) && !out_mispred[gt]);
    p_mispred_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[gt] && out_mispred[gt]) |-> !out_incl[gt]);
    p_taken_only_br_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[gt] && !out_mispred[gt]) |-> !out_taken[gt]);
    p_handled_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      blk_handled[gt] |-> out_valid[gt]);
  end

  p_wrote_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrote |-> (out_valid != '0));
  p_wrote_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid != '0) |-> wrote);
endmodule

bind sqm_top sqm_checker #(
  .NUM_THREADS(NUM_THREADS),
  .NUM_PORTS  (NUM_PORTS),
  .TID_W      (TID_W)
) u_sqm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_vld     (req_vld),
  .req_kind    (req_kind),
  .req_tid     (req_tid),
  .out_valid   (out_valid),
  .out_redir_pc(out_redir_pc),
  .out_inst_pc (out_inst_pc),
  .out_mispred (out_mispred),
  .out_taken   (out_taken),
  .out_incl    (out_incl),
  .blk_handled (blk_handled),
  .wrote       (wrote)
);

// File: tb/test_sqm_top.sv
`timescale 1ns/1ps
module test_sqm_top;
  localparam int NT = 2;
  localparam int NP = 3;
  localparam int TW = 1;

  logic                 clk;
  logic                 rst_n;
  logic [NP-1:0]        req_vld;
  logic [NP-1:0][1:0]   req_kind;
  logic [NP-1:0][TW-1:0] req_tid;
  logic [NP-1:0][15:0]  req_seq;
  logic [NP-1:0][31:0]  req_pc;
  logic [NP-1:0][31:0]  req_npc;
  logic [NP-1:0]        req_taken;
  logic [NT-1:0]        fetch_redir;
  logic [TW-1:0]        qry_tid;
  logic [15:0]          qry_seq;
  logic                 qry_allow;
  logic [NT-1:0]        out_valid;
  logic [NT-1:0][15:0]  out_seq;
  logic [NT-1:0][31:0]  out_redir_pc;
  logic [NT-1:0][31:0]  out_inst_pc;
  logic [NT-1:0]        out_mispred;
  logic [NT-1:0]        out_taken;
  logic [NT-1:0]        out_incl;
  logic [NT-1:0]        blk_handled;
  logic                 wrote;

  sqm_top #(.NUM_THREADS(NT), .NUM_PORTS(NP)) i_sqm_top (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_kind(req_kind),
    .req_tid(req_tid), .req_seq(req_seq), .req_pc(req_pc), .req_npc(req_npc),
    .req_taken(req_taken), .fetch_redir(fetch_redir), .qry_tid(qry_tid),
    .qry_seq(qry_seq), .qry_allow(qry_allow), .out_valid(out_valid),
    .out_seq(out_seq), .out_redir_pc(out_redir_pc), .out_inst_pc(out_inst_pc),
    .out_mispred(out_mispred), .out_taken(out_taken), .out_incl(out_incl),
    .blk_handled(blk_handled), .wrote(wrote)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    bit          v  [NT];
    bit          h  [NT];
    logic [15:0] seq[NT];
    logic [31:0] rpc[NT];
    logic [31:0] ipc[NT];
    bit          mp [NT];
    bit          tk [NT];
    bit          inc[NT];
    bit          w;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // reference merge over the current request inputs, ports in ascending order
  function automatic exp_t model(string tag);
    exp_t e;
    for (int t = 0; t < NT; t++) begin
      e.v[t] = 0; e.h[t] = 0; e.seq[t] = '0; e.rpc[t] = '0; e.ipc[t] = '0;
      e.mp[t] = 0; e.tk[t] = 0; e.inc[t] = 0;
      for (int p = 0; p < NP; p++) begin
        if (req_vld[p] && req_kind[p] != 2'd3 && int'(req_tid[p]) == t &&
            (!e.v[t] || req_seq[p] < e.seq[t])) begin
          e.v[t]   = 1;
          e.seq[t] = req_seq[p];
          e.ipc[t] = req_pc[p];
          e.rpc[t] = (req_kind[p] == 2'd2) ? req_pc[p] : req_npc[p];
          e.mp[t]  = (req_kind[p] == 2'd0);
          e.tk[t]  = (req_kind[p] == 2'd0) && req_taken[p];
          e.inc[t] = (req_kind[p] == 2'd2);
          if (req_kind[p] == 2'd2) e.h[t] = 1;
        end
      end
    end
    e.w   = e.v[0] | e.v[1];
    e.tag = tag;
    return e;
  endfunction

  task automatic clear_reqs();
    req_vld = '0; req_kind = '0; req_tid = '0; req_seq = '0;
    req_pc = '0; req_npc = '0; req_taken = '0;
  endtask

  task automatic set_req(int p, int kind, int tid, int seq, int pc, int npc, bit tk);
    req_vld[p]   = 1'b1;
    req_kind[p]  = 2'(kind);
    req_tid[p]   = TW'(tid);
    req_seq[p]   = 16'(seq);
    req_pc[p]    = 32'(pc);
    req_npc[p]   = 32'(npc);
    req_taken[p] = tk;
  endtask

  // driver: inputs already set at a falling edge; push the expectation
  task automatic push(string tag);
    sb.push_back(model(tag));
  endtask

  task automatic query(int tid, int seq, bit [NT-1:0] fr, string tag);
    bit ex;
    exp_t e;
    qry_tid = TW'(tid); qry_seq = 16'(seq); fetch_redir = fr;
    #1;
    e  = model(tag);
    ex = !fr[tid] || !e.v[tid] || (e.seq[tid] > 16'(seq));
    chk(qry_allow == ex, tag, "qry_allow", qry_allow, ex);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(wrote == e.w, "R8", "wrote", wrote, e.w);
      for (int t = 0; t < NT; t++) begin
        chk(out_valid[t] == e.v[t], e.tag, "valid", out_valid[t], e.v[t]);
        chk(blk_handled[t] == e.h[t], "R6", "handled", blk_handled[t], e.h[t]);
        if (e.v[t]) begin
          chk(out_seq[t] == e.seq[t], e.tag, "seq", out_seq[t], e.seq[t]);
          chk(out_redir_pc[t] == e.rpc[t], e.tag, "redir_pc", out_redir_pc[t], e.rpc[t]);
          chk(out_inst_pc[t] == e.ipc[t], e.tag, "inst_pc", out_inst_pc[t], e.ipc[t]);
          chk(out_mispred[t] == e.mp[t], e.tag, "mispred", out_mispred[t], e.mp[t]);
          chk(out_taken[t] == e.tk[t], e.tag, "taken", out_taken[t], e.tk[t]);
          chk(out_incl[t] == e.inc[t], e.tag, "incl", out_incl[t], e.inc[t]);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    clear_reqs();
    fetch_redir = '0; qry_tid = '0; qry_seq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(out_valid == '0, "R10", "valid", out_valid, 0);
    chk(wrote == 1'b0, "R10", "wrote", wrote, 0);
    chk(blk_handled == '0, "R10", "handled", blk_handled, 0);
    rst_n = 1'b1;

    // R2: single mispredict, taken
    @(negedge clk); clear_reqs();
    set_req(0, 0, 0, 100, 'h1000, 'h1004, 1); push("R2");
    // R3: ordering violation on thread 1
    @(negedge clk); clear_reqs();
    set_req(1, 1, 1, 200, 'h2000, 'h2004, 1); push("R3");
    // R5: blocked load on thread 0
    @(negedge clk); clear_reqs();
    set_req(2, 2, 0, 300, 'h3000, 'h3004, 0); push("R5");
    // R1: younger first, older later replaces
    @(negedge clk); clear_reqs();
    set_req(0, 1, 0, 50, 'h4000, 'h4004, 0);
    set_req(1, 0, 0, 40, 'h4100, 'h4104, 0);
    set_req(2, 1, 0, 45, 'h4200, 'h4204, 0); push("R1");
    // R6: older mispredict first; younger blocked load rejected, no pulse
    @(negedge clk); clear_reqs();
    set_req(0, 0, 1, 10, 'h5000, 'h5004, 1);
    set_req(1, 2, 1, 20, 'h5100, 'h5104, 0); push("R6");
    // R6: blocked load taken then displaced by older request, pulse stays
    @(negedge clk); clear_reqs();
    set_req(0, 2, 0, 90, 'h6000, 'h6004, 0);
    set_req(1, 0, 0, 80, 'h6100, 'h6104, 0); push("R6");
    // R1: equal sequence numbers, lower port kept
    @(negedge clk); clear_reqs();
    set_req(0, 1, 1, 70, 'h7000, 'h7004, 0);
    set_req(2, 2, 1, 70, 'h7100, 'h7104, 0); push("R1");
    // R7: both threads at once, independent
    @(negedge clk); clear_reqs();
    set_req(0, 0, 1, 5, 'h8000, 'h8004, 0);
    set_req(1, 2, 0, 900, 'h8100, 'h8104, 0);
    set_req(2, 1, 0, 950, 'h8200, 'h8204, 0); push("R7");
    // R4: kind 3 ignored
    @(negedge clk); clear_reqs();
    set_req(0, 3, 0, 1, 'h9000, 'h9004, 1);
    set_req(1, 3, 1, 1, 'h9100, 'h9104, 1); push("R4");
    // R8: idle
    @(negedge clk); clear_reqs(); push("R8");
    // R11: per-cycle clear, then younger accepted
    @(negedge clk); clear_reqs();
    set_req(0, 1, 0, 10, 'hA000, 'hA004, 0); push("R11");
    @(negedge clk); clear_reqs();
    set_req(0, 0, 0, 500, 'hB000, 'hB004, 1); push("R11");

    // R9: query cases against same-cycle merge
    @(negedge clk); clear_reqs();
    set_req(0, 0, 0, 100, 'hC000, 'hC004, 0); push("R9");
    query(0, 150, 2'b00, "R9");
    query(0, 150, 2'b01, "R9");
    query(0, 100, 2'b01, "R9");
    query(0, 99, 2'b01, "R9");
    query(1, 150, 2'b10, "R9");
    @(negedge clk); clear_reqs(); push("R9");
    query(0, 150, 2'b01, "R9");

    @(negedge clk); clear_reqs();
    repeat (3) @(posedge clk);
    #5;
    finish_run();
  end
endmodule